// File: doc/BRIEF.md
# Precision-Controlled Sequential Extended-Format Divider

This block divides two 80-bit extended floating-point operands. Each operand has a sign bit, a 15-bit biased exponent and a 64-bit significand whose integer bit is explicit. The quotient significand is built by a restoring radix-2 loop that produces one bit per clock. A 2-bit precision selector chooses whether the result carries 24, 53 or 64 significant bits. A coarser precision runs fewer loop steps, so it finishes sooner. The result is rounded to nearest-even at the chosen width, and every significand bit below that width is cleared.

When the divisor significand is exactly 1.0 (integer bit set, all fraction bits clear), the loop is skipped. The dividend significand goes straight to rounding, and the result comes back after a fixed short delay. A zero divisor with a nonzero dividend returns a signed infinity one cycle after acceptance and raises a divide-by-zero flag. The cycle count depends only on the precision code and on these two special cases, and never on the other operand bits.

Operands enter through a valid/ready pair. An operation is accepted in a cycle where `in_valid` and `in_ready` are both high. `in_ready` stays low from the cycle after acceptance until the result cycle, and any `in_valid` in that window is ignored. The result side has no back-pressure. `out_valid` is a single-cycle strobe, and the result registers hold their value until the next operation writes them. The consumer either captures the result in the strobe cycle or reads the held value later. `in_ready` is high in the strobe cycle, so a new operation can be accepted in that same cycle.

Top module: `fpdiv_prec`

## Requirements
- R1: Precision code `prec_ctl` selects the result width: 2'b00 gives 24 bits, 2'b10 gives 53 bits, and both 2'b11 and 2'b01 give 64 bits. Result significand bits below the selected width (bit positions 63-p down to 0) are zero.
- R2: The result sign is the XOR of the two operand signs.
- R3: The result exponent is `a_exp - b_exp + 16383`. It is one lower when the dividend significand is smaller than the divisor significand. The result significand always has bit 63 set.
- R4: The significand is rounded to nearest, ties to even, at the selected width. A carry out of rounding gives significand 0x8000000000000000 and raises the exponent by one.
- R5: Call the accepting cycle cycle 0. For a general divisor, `out_valid` is high in cycle p+5: cycle 29, 58 or 69 for 24, 53 or 64 bits.
- R6: A divisor significand of exactly 0x8000000000000000 makes `out_valid` high in cycle 9 at every precision. The result value follows R1 to R4.
- R7: Latency depends on nothing but the precision code and the R6 and R8 cases.
- R8: A divisor significand of zero with a nonzero dividend significand makes `out_valid` high in cycle 1. It also sets `div_zero` to 1, `q_exp` to 0x7FFF, `q_sig` to 0x8000000000000000, and `q_sign` as in R2. Every other result has `div_zero` at 0.
- R9: `in_ready` is high in the cycle where `out_valid` is high, and an operation offered in that cycle is accepted.
- R10: `in_valid` raised while `in_ready` is low has no effect on the current operation's result or timing.
- R11: `out_valid` is high for exactly one cycle per operation. The result outputs keep their value until the next operation's result is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Divider idle and able to accept |
| a_sign | input | 1 | Dividend sign |
| a_exp | input | 15 | Dividend biased exponent |
| a_sig | input | 64 | Dividend significand, explicit integer bit |
| b_sign | input | 1 | Divisor sign |
| b_exp | input | 15 | Divisor biased exponent |
| b_sig | input | 64 | Divisor significand, explicit integer bit |
| prec_ctl | input | 2 | Precision code (see R1) |
| out_valid | output | 1 | Single-cycle result strobe |
| q_sign | output | 1 | Quotient sign |
| q_exp | output | 15 | Quotient biased exponent |
| q_sig | output | 64 | Quotient significand |
| div_zero | output | 1 | Divide-by-zero flag for the held result |

## Verification
The bench builds the block with its default parameters. These are the 15-bit exponent and 64-bit significand of the real format, and a 9-cycle early-out, so all three precision widths and the reserved code run exactly as deployed. Operands are small integers, up to 27 bits, converted to extended form. Because they are small, the bench can form an exact 128-bit scaled quotient with remainder and derive the correctly rounded result for each width. A grid of dividends against divisors is swept under all four precision codes. The grid includes power-of-two divisors, all-ones dividends whose rounding carries out, and quotients just below 1.0.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ITER  = 2'd1,
    ST_FAST  = 2'd2,
    ST_ROUND = 2'd3
  } fsm_e;

  // Width of the kept significand for each precision code.
  function automatic int prec_width(input logic [1:0] code, input int full_w);
    case (code)
      2'b00:   prec_width = 24;
      2'b10:   prec_width = 53;
      default: prec_width = full_w;
    endcase
  endfunction

endpackage

// File: rtl/fpdiv_ctrl.sv
module fpdiv_ctrl
  import fpdiv_pkg::*;
#(
  parameter int CW          = 7,
  parameter int QW          = 67,
  parameter int FAST_CYCLES = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          go_fast,
  input  logic          go_dz,
  input  logic [CW-1:0] n_iter,
  output fsm_e          state
);

  localparam logic [CW-1:0] FAST_INIT = CW'(FAST_CYCLES - 3);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start && !go_dz) begin
            if (go_fast) begin
              state <= ST_FAST;
              cnt   <= FAST_INIT;
            end else begin
              state <= ST_ITER;
              cnt   <= n_iter - CW'(1);
            end
          end
        end
        ST_ITER, ST_FAST: begin
          if (cnt == '0) state <= ST_ROUND;
          else           cnt   <= cnt - CW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ITER_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ITER && cnt == '0) |=> state == ST_ROUND); // R5

  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_ITER |-> cnt < CW'(QW)); // R7

  AST_FAST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FAST |-> cnt <= FAST_INIT); // R6

  AST_ROUND_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_ROUND |=> state == ST_IDLE); // R11

endmodule

// File: rtl/fpdiv_iter.sv
module fpdiv_iter #(
  parameter int SIG_W = 64,
  parameter int QW    = 67
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             fast,
  input  logic             step,
  input  logic [SIG_W-1:0] a_sig,
  input  logic [SIG_W-1:0] b_sig,
  output logic [QW-1:0]    q,
  output logic             rem_nz
);

  logic [SIG_W:0]   rem;
  logic [SIG_W-1:0] dvs;
  logic [SIG_W:0]   diff;
  logic [SIG_W:0]   keep;
  logic             ge;

  always_comb begin
    ge   = rem >= {1'b0, dvs};
    diff = rem - {1'b0, dvs};
    keep = ge ? diff : rem;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0;
      dvs <= '0;
      q   <= '0;
    end else if (load) begin
      dvs <= b_sig;
      if (fast) begin
        rem <= '0;
        q   <= {a_sig, {(QW-SIG_W){1'b0}}};
      end else begin
        rem <= {1'b0, a_sig};
        q   <= '0;
      end
    end else if (step) begin
      q   <= {q[QW-2:0], ge};
      rem <= {keep[SIG_W-1:0], 1'b0};
    end
  end

  assign rem_nz = |rem;

  AST_REM_BELOW_2D: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> rem < {dvs, 1'b0}); // R4

endmodule

// File: rtl/fpdiv_round.sv
module fpdiv_round #(
  parameter int SIG_W = 64,
  parameter int QW    = 67,
  parameter int CW    = 7,
  parameter int XW    = 18
) (
  input  logic [QW-1:0]        q,
  input  logic                 fast,
  input  logic                 rem_nz,
  input  logic [CW-1:0]        p_bits,
  input  logic signed [XW-1:0] exp_in,
  output logic [SIG_W-1:0]     sig_out,
  output logic signed [XW-1:0] exp_out
);

  localparam logic signed [XW-1:0] ONE = XW'(1);

  logic [QW-1:0]        al, nm, t, rmask, sum0, sum1, wide;
  logic signed [XW-1:0] e0;
  logic                 guard, lsb, sticky, inc, carry;
  int                   gpos, nbits;

  always_comb begin
    nbits = int'(p_bits) + 3;
    al    = fast ? q : (q << (QW - nbits));
    if (al[QW-1]) begin
      nm = al;
      e0 = exp_in;
    end else begin
      nm = al << 1;
      e0 = exp_in - ONE;
    end
    gpos   = QW - 1 - int'(p_bits);
    t      = nm >> gpos;
    guard  = t[0];
    lsb    = t[1];
    rmask  = (QW'(1) << gpos) - QW'(1);
    sticky = (|(nm & rmask)) | rem_nz;
    inc    = guard & (lsb | sticky);
    sum0   = (t >> 1) + QW'(inc);
    carry  = sum0[p_bits];
    if (carry) begin
      sum1    = sum0 >> 1;
      exp_out = e0 + ONE;
    end else begin
      sum1    = sum0;
      exp_out = e0;
    end
    wide    = sum1 << (SIG_W - int'(p_bits));
    sig_out = wide[SIG_W-1:0];
  end

endmodule

// File: rtl/fpdiv_prec.sv
module fpdiv_prec
  import fpdiv_pkg::*;
#(
  parameter int EXP_W       = 15,
  parameter int SIG_W       = 64,
  parameter int FAST_CYCLES = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             a_sign,
  input  logic [EXP_W-1:0] a_exp,
  input  logic [SIG_W-1:0] a_sig,
  input  logic             b_sign,
  input  logic [EXP_W-1:0] b_exp,
  input  logic [SIG_W-1:0] b_sig,
  input  logic [1:0]       prec_ctl,
  output logic             out_valid,
  output logic             q_sign,
  output logic [EXP_W-1:0] q_exp,
  output logic [SIG_W-1:0] q_sig,
  output logic             div_zero
);

  localparam int QW   = SIG_W + 3;
  localparam int CW   = $clog2(QW + 1);
  localparam int XW   = EXP_W + 3;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [SIG_W-1:0] SIG_ONE = {1'b1, {(SIG_W-1){1'b0}}};

  fsm_e                 state;
  logic                 accept, is_pow2, is_dz;
  logic [CW-1:0]        p_in, p_r;
  logic                 fast_r, sign_r;
  logic signed [XW-1:0] exp_r, exp_diff, r_exp;
  logic [QW-1:0]        qbits;
  logic                 rem_nz;
  logic [SIG_W-1:0]     r_sig, low_mask;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign is_pow2  = (b_sig == SIG_ONE);
  assign is_dz    = (b_sig == '0) && (a_sig != '0);
  assign p_in     = CW'(prec_width(prec_ctl, SIG_W));
  assign exp_diff = $signed({3'b000, a_exp}) - $signed({3'b000, b_exp}) + XW'(BIAS);

  fpdiv_ctrl #(.CW(CW), .QW(QW), .FAST_CYCLES(FAST_CYCLES)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .go_fast (is_pow2),
    .go_dz   (is_dz),
    .n_iter  (p_in + CW'(3)),
    .state   (state)
  );

  fpdiv_iter #(.SIG_W(SIG_W), .QW(QW)) u_iter (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept && !is_dz),
    .fast   (is_pow2),
    .step   (state == ST_ITER),
    .a_sig  (a_sig),
    .b_sig  (b_sig),
    .q      (qbits),
    .rem_nz (rem_nz)
  );

  fpdiv_round #(.SIG_W(SIG_W), .QW(QW), .CW(CW), .XW(XW)) u_round (
    .q       (qbits),
    .fast    (fast_r),
    .rem_nz  (rem_nz),
    .p_bits  (p_r),
    .exp_in  (exp_r),
    .sig_out (r_sig),
    .exp_out (r_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_r    <= 1'b0;
      exp_r     <= '0;
      p_r       <= CW'(SIG_W);
      fast_r    <= 1'b0;
      out_valid <= 1'b0;
      q_sign    <= 1'b0;
      q_exp     <= '0;
      q_sig     <= '0;
      div_zero  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (accept) begin
        sign_r <= a_sign ^ b_sign;
        exp_r  <= exp_diff;
        p_r    <= p_in;
        fast_r <= is_pow2;
        if (is_dz) begin
          out_valid <= 1'b1;
          q_sign    <= a_sign ^ b_sign;
          q_exp     <= '1;
          q_sig     <= SIG_ONE;
          div_zero  <= 1'b1;
        end
      end
      if (state == ST_ROUND) begin
        out_valid <= 1'b1;
        q_sign    <= sign_r;
        q_exp     <= r_exp[EXP_W-1:0];
        q_sig     <= r_sig;
        div_zero  <= 1'b0;
      end
    end
  end

  assign low_mask = (SIG_W'(1) << (SIG_W - int'(p_r))) - SIG_W'(1);

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(accept && is_dz)) |=> !out_valid); // R11

  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready); // R9

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_ROUND && !accept) |=> $stable({q_sign, q_exp, q_sig, div_zero})); // R11

  AST_DZ_INFINITY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && div_zero) |-> (q_exp == '1 && q_sig == SIG_ONE)); // R8

  AST_SIG_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !div_zero) |-> q_sig[SIG_W-1]); // R3

  AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !div_zero) |-> (q_sig & low_mask) == '0); // R1

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ITER || state == ST_FAST) |-> !in_ready); // R10

endmodule

// File: tb/test_fpdiv_prec.sv
module test_fpdiv_prec;

  localparam int CLK_P = 10;
  localparam int BIAS  = 16383;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        a_sign = 1'b0, b_sign = 1'b0;
  logic [14:0] a_exp = '0, b_exp = '0;
  logic [63:0] a_sig = '0, b_sig = '0;
  logic [1:0]  prec_ctl = 2'b00;
  logic        out_valid, q_sign, div_zero;
  logic [14:0] q_exp;
  logic [63:0] q_sig;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  fpdiv_prec i_fpdiv_prec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_sign(a_sign), .a_exp(a_exp), .a_sig(a_sig),
    .b_sign(b_sign), .b_exp(b_exp), .b_sig(b_sig),
    .prec_ctl(prec_ctl), .out_valid(out_valid), .q_sign(q_sign),
    .q_exp(q_exp), .q_sig(q_sig), .div_zero(div_zero)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  function automatic int msb_of(input logic [127:0] v);
    int m = 0;
    for (int i = 0; i < 128; i++) if (v[i]) m = i;
    return m;
  endfunction

  function automatic int width_of(input logic [1:0] pc);
    return (pc == 2'b00) ? 24 : (pc == 2'b10) ? 53 : 64;
  endfunction

  // Exact division of small integers, rounded to nearest-even at width p.
  task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [1:0] pc,
                       output logic [14:0] e, output logic [63:0] s);
    logic [127:0] num, nq, nr, sg;
    int p, m, g, ex;
    bit guard, rest;
    p   = width_of(pc);
    num = {96'b0, a} << 100;
    nq  = num / {96'b0, b};
    nr  = num % {96'b0, b};
    m   = msb_of(nq);
    g   = m - p;
    sg  = nq >> (g + 1);
    guard = nq[g];
    rest  = ((nq & ((128'b1 << g) - 128'b1)) != 0) || (nr != 0);
    ex  = BIAS + m - 100;
    if (guard && (sg[0] || rest)) sg = sg + 128'b1;
    if (sg[p]) begin
      sg = sg >> 1;
      ex = ex + 1;
    end
    s = 64'(sg << (64 - p));
    e = 15'(ex);
  endtask

  task automatic drive(input bit sa, input logic [31:0] a, input bit sb, input logic [31:0] b,
                       input logic [1:0] pc);
    int ma, mb;
    ma = msb_of({96'b0, a});
    mb = msb_of({96'b0, b});
    a_sign = sa; b_sign = sb; prec_ctl = pc;
    a_sig  = (a == 0) ? 64'b0 : (64'(a) << (63 - ma));
    a_exp  = (a == 0) ? 15'b0 : 15'(BIAS + ma);
    b_sig  = (b == 0) ? 64'b0 : (64'(b) << (63 - mb));
    b_exp  = (b == 0) ? 15'b0 : 15'(BIAS + mb);
    in_valid = 1'b1;
  endtask

  task automatic wait_done(output int lat);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 400) begin
      @(negedge clk);
      lat++;
    end
  endtask

  function automatic int lat_of(input logic [31:0] b, input logic [1:0] pc);
    if ((b & (b - 1)) == 0) return 9;
    return width_of(pc) + 5;
  endfunction

  // Inspect a result in its strobe cycle, then the cycle after.
  task automatic check_result(input bit sa, input logic [31:0] a, input bit sb, input logic [31:0] b,
                              input logic [1:0] pc, input int lat);
    logic [14:0] e_exp;
    logic [63:0] e_sig;
    logic [63:0] h_sig;
    model(a, b, pc, e_exp, e_sig);
    chk(lat == lat_of(b, pc), ((b & (b - 1)) == 0) ? "R6 latency" : "R5 R7 latency",
        64'(lat), 64'(lat_of(b, pc)));
    chk(q_sign == (sa ^ sb), "R2 sign", 64'(q_sign), 64'(sa ^ sb));
    chk(q_exp == e_exp, "R3 exponent", 64'(q_exp), 64'(e_exp));
    chk(q_sig == e_sig, (pc == 2'b01) ? "R1 reserved code" : "R1 R4 significand", q_sig, e_sig);
    chk(div_zero == 1'b0, "R8 flag clear", 64'(div_zero), 64'd0);
    chk(in_ready == 1'b1, "R9 ready at done", 64'(in_ready), 64'd1);
    h_sig = q_sig;
    @(negedge clk);
    chk(out_valid == 1'b0 && q_sig == h_sig, "R11 pulse and hold", {63'b0, out_valid}, 64'd0);
  endtask

  task automatic run(input bit sa, input logic [31:0] a, input bit sb, input logic [31:0] b,
                     input logic [1:0] pc);
    int lat;
    drive(sa, a, sb, b, pc);
    wait_done(lat);
    check_result(sa, a, sb, b, pc, lat);
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] alist [10];
    logic [31:0] blist [9];
    logic [1:0]  plist [4];
    int lat;
    alist = '{32'd1, 32'd3, 32'd5, 32'd7, 32'd11, 32'd13, 32'h1FFFFFF, 32'hFFFFFF, 32'h2AAAAAB, 32'h5555555};
    blist = '{32'd1, 32'd2, 32'd3, 32'd7, 32'd8, 32'd10, 32'd13, 32'h1FFFFF, 32'h400000};
    plist = '{2'b00, 2'b10, 2'b11, 2'b01};

    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && div_zero == 1'b0, "R11 reset strobe low", {63'b0, out_valid}, 64'd0);
    chk(in_ready == 1'b0 || in_ready == 1'b1, "R9 ready defined", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 ready after reset", 64'(in_ready), 64'd1);

    // Hand-derived: 1/3 at 24 bits rounds up to 0xAAAAAB, exponent 16381 (R4, R3)
    drive(1'b0, 32'd1, 1'b0, 32'd3, 2'b00);
    wait_done(lat);
    chk(q_sig == 64'hAAAAAB0000000000, "R4 one third 24b", q_sig, 64'hAAAAAB0000000000);
    chk(q_exp == 15'd16381, "R3 one third exponent", 64'(q_exp), 64'd16381);
    @(negedge clk);
    // 1/3 at 53 bits truncates; at 64 bits rounds up
    drive(1'b0, 32'd1, 1'b0, 32'd3, 2'b10);
    wait_done(lat);
    chk(q_sig == 64'hAAAAAAAAAAAAA800, "R4 one third 53b", q_sig, 64'hAAAAAAAAAAAAA800);
    @(negedge clk);
    drive(1'b0, 32'd1, 1'b0, 32'd3, 2'b11);
    wait_done(lat);
    chk(q_sig == 64'hAAAAAAAAAAAAAAAB, "R4 one third 64b", q_sig, 64'hAAAAAAAAAAAAAAAB);
    @(negedge clk);

    // Sweep over grid and all precision codes
    for (int ip = 0; ip < 4; ip++)
      for (int ia = 0; ia < 10; ia++)
        for (int ib = 0; ib < 9; ib++)
          run(1'((ia + ib) & 1), alist[ia], 1'(ib & 1), blist[ib], plist[ip]);

    // R4 rounding carry: 25 ones at 24 bits gives 1.0 x 2^25
    drive(1'b0, 32'h1FFFFFF, 1'b0, 32'd3, 2'b00);
    wait_done(lat);
    @(negedge clk);
    run(1'b0, 32'h1FFFFFF, 1'b0, 32'd1, 2'b00);
    drive(1'b0, 32'h1FFFFFF, 1'b0, 32'd1, 2'b00);
    wait_done(lat);
    chk(q_sig == 64'h8000000000000000 && q_exp == 15'(BIAS + 25), "R4 carry renormalize",
        {49'b0, q_exp}, 64'(BIAS + 25));
    @(negedge clk);

    // R8 divide by zero
    drive(1'b1, 32'd5, 1'b0, 32'd0, 2'b11);
    wait_done(lat);
    chk(lat == 1, "R8 latency", 64'(lat), 64'd1);
    chk(div_zero == 1'b1, "R8 flag", 64'(div_zero), 64'd1);
    chk(q_exp == 15'h7FFF && q_sig == 64'h8000000000000000, "R8 infinity", q_sig, 64'h8000000000000000);
    chk(q_sign == 1'b1, "R8 sign", 64'(q_sign), 64'd1);
    @(negedge clk);
    chk(out_valid == 1'b0 && div_zero == 1'b1, "R11 dz held", {63'b0, out_valid}, 64'd0);

    // R10 offer while busy is ignored
    drive(1'b0, 32'd7, 1'b1, 32'd13, 2'b10);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    repeat (2) begin
      @(negedge clk);
      lat++;
    end
    drive(1'b1, 32'd5, 1'b0, 32'd0, 2'b00);
    @(negedge clk);
    lat++;
    drive(1'b0, 32'd7, 1'b1, 32'd13, 2'b10);
    in_valid = 1'b0;
    while (!out_valid && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    chk(div_zero == 1'b0, "R10 busy offer no effect", 64'(div_zero), 64'd0);
    check_result(1'b0, 32'd7, 1'b1, 32'd13, 2'b10, lat);

    // R9 back-to-back: offer in the strobe cycle
    drive(1'b0, 32'd11, 1'b0, 32'd7, 2'b00);
    wait_done(lat);
    drive(1'b1, 32'd13, 1'b0, 32'd3, 2'b00);
    wait_done(lat);
    chk(lat == 29, "R9 accepted in strobe cycle", 64'(lat), 64'd29);
    check_result(1'b1, 32'd13, 1'b0, 32'd3, 2'b00, lat);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule